// File: doc/BRIEF.md
# Fast-Blank Output Level Selector

This block picks, pixel by pixel, the digital output level of each of several colour channels in a display preamplifier datapath. For every channel it chooses one of five sources: the main picture (already scaled by contrast), a lit on-screen-display colour, an unlit on-screen-display colour, the main picture at half amplitude (the see-through background), or the blanking level. The choice follows a fast-blank strobe, a blanking strobe, one overlay colour bit per channel and a see-through enable bit.

Picture, overlay and see-through levels all sit on top of a pedestal made of the black level plus the brightness offset. A lit overlay colour adds an amplitude equal to the 4-bit overlay gain times a fixed step. The blanking strobe overrides every other input. It drives all channels to a level a fixed distance below black, with no brightness added. Results are registered, so each input set appears at the outputs one clock later.

Top module: `osd_fb_selector`

## Requirements
- R1: With `blank_i` low and `fblank_i` low, each channel n outputs `black_i + bright_i + video_i[n]`. Channel n's video occupies bits `[n*VID_W +: VID_W]` and its level occupies bits `[n*LVL_W +: LVL_W]`.
- R2: With `blank_i` low, `fblank_i` high and the see-through case not selected, a channel whose bit in `osd_bits_i` is 1 outputs `black_i + bright_i + osd_gain_i * OSD_STEP`. The default `OSD_STEP` is 16.
- R3: Under the same conditions as R2, a channel whose overlay bit is 0 outputs `black_i + bright_i`.
- R4: With `blank_i` low, `fblank_i` high, `semi_en_i` high and `osd_bits_i` equal to `SEMI_CODE`, every channel outputs `black_i + bright_i + (video_i[n] >> 1)`. The default `SEMI_CODE` is 3'b101: channel 0 lit, channel 1 unlit, channel 2 lit.
- R5: The see-through case needs both conditions. With `semi_en_i` low, the code `SEMI_CODE` is shown as overlay colours. With `semi_en_i` high, any other code is also shown as overlay colours.
- R6: While `fblank_i` is low, `semi_en_i` and `osd_bits_i` have no effect on any output.
- R7: With `blank_i` high, every channel outputs `black_i - BLANK_OFS`, or 0 if `black_i` is below `BLANK_OFS`. This holds whatever `fblank_i`, `bright_i` or the other inputs are. The default `BLANK_OFS` is 32.
- R8: Any sum above `2**LVL_W - 1` is clamped to `2**LVL_W - 1`. The default clamp value is 1023.
- R9: An input set presented before a rising clock edge appears on `level_o` just after that edge, exactly one cycle of latency.
- R10: While `rst_n` is low at a rising edge, `level_o` becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fblank_i | input | 1 | Overlay insertion strobe |
| blank_i | input | 1 | Blanking strobe, highest priority |
| semi_en_i | input | 1 | Enables see-through half-amplitude video |
| osd_bits_i | input | NCH | Overlay colour bit per channel (bit n = channel n) |
| osd_gain_i | input | OSDC_W | Overlay amplitude code |
| bright_i | input | BRT_W | Brightness offset |
| black_i | input | LVL_W | Black level |
| video_i | input | NCH*VID_W | Contrast-scaled video per channel |
| level_o | output | NCH*LVL_W | Registered output level per channel |

## Verification
A wrong source decision is confined to one pixel. It shows on the very next cycle as a channel level that matches a different source: for example, the bare pedestal where a lit colour was expected, or a full-amplitude picture where half was expected. The scoreboard compares every registered output against a model one cycle after the input. A fault in the see-through code match, the blanking priority or the clamp is therefore reported on the first pixel that exercises it. Directed pixels cover each source, the near-miss codes around the see-through code, blanking below the offset and clamping. They are followed by a long run of pseudo-random pixels.

// File: rtl/osd_sel_pkg.sv
// Package: shared source-select type for the fast-blank output selector.
// Assumes: nothing beyond IEEE 1800-2017.
package osd_sel_pkg;

    typedef enum logic [2:0] {
        SRC_VIDEO   = 3'd0,
        SRC_OSD_ON  = 3'd1,
        SRC_OSD_OFF = 3'd2,
        SRC_SEMI    = 3'd3,
        SRC_BLANK   = 3'd4
    } src_e;

endpackage

// File: rtl/osd_src_decode.sv
// Module: osd_src_decode
// Decides, per channel, which source drives the output level this pixel.
// Assumes: blanking outranks overlay, overlay outranks picture; the
// see-through code is matched on all channel bits together.
module osd_src_decode
    import osd_sel_pkg::*;
#(
    parameter int          NCH       = 3,
    parameter logic [NCH-1:0] SEMI_CODE = 3'b101
) (
    input  logic           fblank_i,
    input  logic           blank_i,
    input  logic           semi_en_i,
    input  logic [NCH-1:0] osd_bits_i,
    output src_e           src_o [NCH]
);

    logic see_through;

    // Purpose: detect the single overlay code shown as half video.
    always_comb begin
        see_through = semi_en_i && (osd_bits_i == SEMI_CODE);
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        // Purpose: priority choice of the source for channel n.
        always_comb begin
            if (blank_i)
                src_o[n] = SRC_BLANK;
            else if (!fblank_i)
                src_o[n] = SRC_VIDEO;
            else if (see_through)
                src_o[n] = SRC_SEMI;
            else if (osd_bits_i[n])
                src_o[n] = SRC_OSD_ON;
            else
                src_o[n] = SRC_OSD_OFF;
        end
    end

endmodule

// File: rtl/osd_chan_level.sv
// Module: osd_chan_level
// Combinational level for one channel from its chosen source.
// Assumes: VID_W and BRT_W do not exceed LVL_W; osd_amp_i and blank_lvl_i
// are already limited to LVL_W bits by the caller.
module osd_chan_level
    import osd_sel_pkg::*;
#(
    parameter int VID_W = 8,
    parameter int BRT_W = 8,
    parameter int LVL_W = 10
) (
    input  src_e             src_i,
    input  logic [VID_W-1:0] video_i,
    input  logic [BRT_W-1:0] bright_i,
    input  logic [LVL_W-1:0] black_i,
    input  logic [LVL_W-1:0] osd_amp_i,
    input  logic [LVL_W-1:0] blank_lvl_i,
    output logic [LVL_W-1:0] level_o
);

    localparam int SUM_W = LVL_W + 2;
    localparam logic [SUM_W-1:0] LVL_MAX = SUM_W'((1 << LVL_W) - 1);

    logic [LVL_W-1:0] term;
    logic [SUM_W-1:0] sum;

    // Purpose: pick the signal term that rides on the pedestal.
    always_comb begin
        unique case (src_i)
            SRC_VIDEO:  term = LVL_W'(video_i);
            SRC_SEMI:   term = LVL_W'(video_i >> 1);
            SRC_OSD_ON: term = osd_amp_i;
            default:    term = '0;
        endcase
    end

    // Purpose: pedestal plus term, clamped, or the blanking level.
    always_comb begin
        sum = SUM_W'(black_i) + SUM_W'(bright_i) + SUM_W'(term);
        if (src_i == SRC_BLANK)
            level_o = blank_lvl_i;
        else if (sum > LVL_MAX)
            level_o = LVL_MAX[LVL_W-1:0];
        else
            level_o = sum[LVL_W-1:0];
    end

endmodule

// File: rtl/osd_fb_selector.sv
// Module: osd_fb_selector (top)
// Per-pixel output selector for NCH colour channels: picture, overlay
// colour, see-through half video or blanking, registered once.
// Assumes: overlay amplitude = gain code * OSD_STEP; blanking level is
// black minus BLANK_OFS, floored at zero.
module osd_fb_selector
    import osd_sel_pkg::*;
#(
    parameter int             NCH       = 3,
    parameter int             VID_W     = 8,
    parameter int             BRT_W     = 8,
    parameter int             OSDC_W    = 4,
    parameter int             LVL_W     = 10,
    parameter int             OSD_STEP  = 16,
    parameter int             BLANK_OFS = 32,
    parameter logic [NCH-1:0] SEMI_CODE = 3'b101
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fblank_i,
    input  logic                 blank_i,
    input  logic                 semi_en_i,
    input  logic [NCH-1:0]       osd_bits_i,
    input  logic [OSDC_W-1:0]    osd_gain_i,
    input  logic [BRT_W-1:0]     bright_i,
    input  logic [LVL_W-1:0]     black_i,
    input  logic [NCH*VID_W-1:0] video_i,
    output logic [NCH*LVL_W-1:0] level_o
);

    localparam int LVL_MAX = (1 << LVL_W) - 1;

    src_e             src   [NCH];
    logic [LVL_W-1:0] lvl_d [NCH];
    logic [LVL_W-1:0] lvl_q [NCH];
    logic [31:0]      amp_full;
    logic [LVL_W-1:0] osd_amp;
    logic [LVL_W-1:0] blank_lvl;

    // Purpose: overlay amplitude from gain code, clamped to the level range.
    always_comb begin
        amp_full = 32'(osd_gain_i) * 32'(OSD_STEP);
        osd_amp  = (amp_full > 32'(LVL_MAX)) ? LVL_W'(LVL_MAX) : amp_full[LVL_W-1:0];
    end

    // Purpose: blanking level below black, floored at zero.
    always_comb begin
        blank_lvl = (32'(black_i) > 32'(BLANK_OFS)) ? (black_i - LVL_W'(BLANK_OFS)) : '0;
    end

    osd_src_decode #(
        .NCH       (NCH),
        .SEMI_CODE (SEMI_CODE)
    ) u_decode (
        .fblank_i   (fblank_i),
        .blank_i    (blank_i),
        .semi_en_i  (semi_en_i),
        .osd_bits_i (osd_bits_i),
        .src_o      (src)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        osd_chan_level #(
            .VID_W (VID_W),
            .BRT_W (BRT_W),
            .LVL_W (LVL_W)
        ) u_level (
            .src_i       (src[n]),
            .video_i     (video_i[n*VID_W +: VID_W]),
            .bright_i    (bright_i),
            .black_i     (black_i),
            .osd_amp_i   (osd_amp),
            .blank_lvl_i (blank_lvl),
            .level_o     (lvl_d[n])
        );

        // Purpose: one pipeline register per channel, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q[n] <= '0;
            else
                lvl_q[n] <= lvl_d[n];
        end

        assign level_o[n*LVL_W +: LVL_W] = lvl_q[n];

        // R7: blanking drives every channel to the same level.
        a_r7_blank_uniform: assert property (@(posedge clk) disable iff (!rst_n)
            blank_i |=> (lvl_q[n] == lvl_q[0]));

        // R3: all overlay bits clear (and not the see-through code) gives one shared pedestal.
        a_r3_dark_uniform: assert property (@(posedge clk) disable iff (!rst_n)
            (fblank_i && !blank_i && osd_bits_i == '0 && !(semi_en_i && SEMI_CODE == '0))
            |=> (lvl_q[n] == lvl_q[0]));
    end

    // R7: blanking level never exceeds black.
    a_r7_below_black: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |=> (lvl_q[0] <= $past(black_i)));

    // R1: the picture never falls below black.
    a_r1_video_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!fblank_i && !blank_i) |=> (lvl_q[0] >= $past(black_i)));

    // R10: reset clears the outputs on the next edge.
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (level_o == '0));

endmodule

// File: tb/osd_fb_selector_tb.sv
module osd_fb_selector_tb;

    localparam int NCH = 3, VID_W = 8, BRT_W = 8, OSDC_W = 4, LVL_W = 10;
    localparam int STEP = 16, BOFS = 32, MAXL = 1023;

    logic                 clk = 0;
    logic                 rst_n = 0;
    logic                 fblank_i = 0, blank_i = 0, semi_en_i = 0;
    logic [NCH-1:0]       osd_bits_i = '0;
    logic [OSDC_W-1:0]    osd_gain_i = '0;
    logic [BRT_W-1:0]     bright_i = '0;
    logic [LVL_W-1:0]     black_i = '0;
    logic [NCH*VID_W-1:0] video_i = '0;
    logic [NCH*LVL_W-1:0] level_o;

    int checks = 0, fails = 0;
    logic [NCH*LVL_W-1:0] exp_q[$];
    string                tag_q[$];

    always #5 clk = ~clk;

    osd_fb_selector u_dut (
        .clk(clk), .rst_n(rst_n), .fblank_i(fblank_i), .blank_i(blank_i),
        .semi_en_i(semi_en_i), .osd_bits_i(osd_bits_i), .osd_gain_i(osd_gain_i),
        .bright_i(bright_i), .black_i(black_i), .video_i(video_i), .level_o(level_o)
    );

    function automatic int clampl(int v);
        return (v > MAXL) ? MAXL : v;
    endfunction

    // Reference: expected level of channel n from the requirement text.
    function automatic int model(int n, bit fb, bit bl, bit se, int bits, int g,
                                 int br, int bk, int v);
        int ped;
        ped = bk + br;
        if (bl) return (bk > BOFS) ? bk - BOFS : 0;
        if (!fb) return clampl(ped + v);
        if (se && bits == 5) return clampl(ped + v / 2);
        if ((bits >> n) & 1) return clampl(ped + g * STEP);
        return clampl(ped);
    endfunction

    // Driver: apply one pixel on a falling edge and queue its expected output.
    task automatic drive(bit fb, bit bl, bit se, int bits, int g, int br, int bk,
                         int v0, int v1, int v2, string tag);
        logic [NCH*LVL_W-1:0] e;
        int v[3];
        v[0] = v0; v[1] = v1; v[2] = v2;
        @(negedge clk);
        fblank_i = fb; blank_i = bl; semi_en_i = se; osd_bits_i = NCH'(bits);
        osd_gain_i = OSDC_W'(g); bright_i = BRT_W'(br); black_i = LVL_W'(bk);
        video_i = {VID_W'(v2), VID_W'(v1), VID_W'(v0)};
        for (int n = 0; n < NCH; n++)
            e[n*LVL_W +: LVL_W] = LVL_W'(model(n, fb, bl, se, bits, g, br, bk, v[n]));
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: one cycle after each driven pixel, compare (R9 latency).
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [NCH*LVL_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (level_o !== e) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", t, level_o, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_500_000;
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (level_o !== '0) begin
            fails++;
            $display("FAIL R10: got %h expected 0", level_o);
        end
        @(negedge clk);
        rst_n = 1;
        drive(0, 0, 0, 0, 0, 50, 100, 10, 200, 255, "R1 video");
        drive(1, 0, 1, 6, 15, 50, 100, 5, 200, 254, "R2 R3 R5 lit/unlit code 110");
        drive(1, 0, 0, 0, 9, 20, 300, 1, 2, 3, "R3 all unlit");
        drive(1, 0, 1, 5, 15, 50, 100, 5, 200, 255, "R4 see-through");
        drive(1, 0, 0, 5, 15, 50, 100, 5, 200, 255, "R5 code 101 without enable");
        drive(1, 0, 1, 4, 7, 50, 100, 5, 200, 255, "R5 near code 100");
        drive(0, 0, 1, 5, 15, 50, 100, 30, 60, 90, "R6 enable ignored without fblank");
        drive(1, 1, 1, 5, 15, 255, 100, 30, 60, 90, "R7 blank over overlay");
        drive(0, 1, 0, 0, 0, 255, 20, 255, 255, 255, "R7 blank floored at zero");
        drive(0, 0, 0, 0, 0, 255, 1000, 255, 0, 100, "R8 video clamp");
        drive(1, 0, 0, 7, 15, 255, 900, 0, 0, 0, "R8 overlay clamp");
        drive(0, 0, 0, 0, 0, 1, 2, 3, 4, 5, "R9 back-to-back a");
        drive(1, 0, 0, 2, 1, 1, 2, 3, 4, 5, "R9 back-to-back b");
        for (int i = 0; i < 300; i++) begin
            int r;
            r = $urandom;
            drive(r[0], (r[3:1] == 0), r[4], r[7:5], r[11:8], $urandom % 256,
                  $urandom % 1024, $urandom % 256, $urandom % 256, $urandom % 256,
                  "R1 R2 R3 R4 R7 R8 random");
        end
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        #2;
        checks++;
        if (level_o !== '0) begin
            fails++;
            $display("FAIL R10 mid-run: got %h expected 0", level_o);
        end
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule